// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block steers every CPU bus address toward the unit that owns it. Software programs eight decode windows through a register write port. Each window has a control word, a base address and a pair of remap words. A further register places a 1 MB internal device-register region anywhere in the 32-bit space. A combinational lookup port takes an address and reports one of three outcomes: the address falls in the internal region, it hits a window, or it misses. On a window hit the port also returns the window's 4-bit target ID, its 8-bit attribute byte and the address to forward. That forwarded address is 64 bits wide, so the first four windows can relocate traffic into a larger target space.

Window sizes are coarse, in multiples of 64 KB, and are encoded as a count of units minus one. A single window can therefore span anything from 64 KB to the whole 4 GB space. Overlapping windows are resolved by fixed priority. The internal region is checked ahead of all the windows. A read port returns any register, so software can confirm what it programmed.

Top module: `awd_addr_decoder`

## Requirements
- R1: After synchronous reset every window is disabled, so every lookup outside the internal region reports a miss. The internal base reads 32'hF100_0000 and all other registers read zero.
- R2: Register select on wr_addr and rd_addr: 6'h20 is the internal base. When bit 5 is 0, bits 4:2 pick the window and bits 1:0 pick the word: 0 control, 1 base, 2 remap low, 3 remap high. A write lands on the clock edge where wr_en is sampled high. rd_data is a combinational read of the current value, and addresses that map to nothing read zero.
- R3: Control bit 0 enables the window. A window with this bit at 0 never hits. Control bits 3:1 are not stored and read back as zero.
- R4: On a window hit, lk_target is control bits 7:4 and lk_attr is control bits 15:8 of the winning window.
- R5: Window i hits when it is enabled and ((lk_addr - {base[31:16],16'h0}) >> 16) <= control[31:16], with the subtraction taken modulo 2^32. The low 16 bits of the base do not affect matching but read back as written.
- R6: On a hit in windows 0 to 3, lk_fwd_addr is {remap_high, remap_low} plus the 32-bit offset into the window, summed as a 64-bit value.
- R7: Windows 4 to 7 forward {32'h0, lk_addr}. Writes to their remap words are ignored, and those words always read zero.
- R8: When lk_addr[31:20] equals internal_base[31:20], lk_internal is 1 whatever the windows say. In that case lk_hit and lk_miss are 0, target and attribute are 0, and lk_fwd_addr is {32'h0, lk_addr}.
- R9: The internal base reads back exactly as written, including bits 19:0.
- R10: When several enabled windows match, the lowest-numbered one supplies target, attribute and forwarded address.
- R11: Exactly one of lk_hit, lk_miss and lk_internal is 1. On a miss, target and attribute are 0 and lk_fwd_addr is {32'h0, lk_addr}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | Address hit a window |
| lk_miss | output | 1 | Address hit neither a window nor the internal region |
| lk_internal | output | 1 | Address is inside the internal register region |
| lk_target | output | 4 | Target ID of the winning window |
| lk_attr | output | 8 | Attribute byte of the winning window |
| lk_fwd_addr | output | 64 | Address forwarded to the target |

## Verification
The hardest situations to reach are the exact window edges under overlap. These include the last 64 KB unit of a window, the first address past it, and a remap sum that carries into the high word, all while another window or the internal region covers the same address. Uniformly random addresses almost never land there. Directed sequences therefore program overlapping windows, a 4 GB window and a remap that carries, then probe the first byte, the last byte and the neighbours on either side. The random phase reprograms windows with small sizes and aims most addresses within a couple of units of a chosen window's base, so edges and overlaps come up often.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int NUM_WIN        = 8;
    localparam int NUM_REMAP      = 4;
    localparam int AW             = 32;
    localparam int TW             = 4;
    localparam int ATW            = 8;
    localparam int FW             = 2 * AW;
    localparam int GRAN_LSB       = 16;
    localparam int INT_REGION_LSB = 20;
    localparam int WIN_IDX_W      = $clog2(NUM_WIN);
    localparam int RA_W           = WIN_IDX_W + 3;
    localparam logic [RA_W-1:0] INT_SEL = RA_W'(1) << (RA_W - 1);
    localparam logic [AW-1:0]   IBASE_RST = 32'hF100_0000;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_BASE = 2'd1,
        REG_RLO  = 2'd2,
        REG_RHI  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [15:0] size_m1;
        logic [7:0]  attr;
        logic [3:0]  target;
        logic [2:0]  rsvd;
        logic        en;
    } win_ctrl_t;

    function automatic win_ctrl_t ctrl_clean(input logic [31:0] w);
        win_ctrl_t c;
        c      = win_ctrl_t'(w);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int N_WIN   = NUM_WIN,
    parameter int N_REMAP = NUM_REMAP,
    parameter logic [31:0] IB_RST = IBASE_RST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [31:0]      rd_data,
    output logic             win_en     [N_WIN],
    output logic [15:0]      win_size   [N_WIN],
    output logic [TW-1:0]    win_tgt    [N_WIN],
    output logic [ATW-1:0]   win_attr   [N_WIN],
    output logic [15:0]      win_base_hi[N_WIN],
    output logic [FW-1:0]    win_remap  [N_REMAP],
    output logic [AW-1:INT_REGION_LSB] int_base_hi
);

    win_ctrl_t   ctrl_q [N_WIN];
    logic [31:0] base_q [N_WIN];
    logic [31:0] rlo_q  [N_REMAP];
    logic [31:0] rhi_q  [N_REMAP];
    logic [31:0] ibase_q;

    logic                 wr_is_int, wr_is_win, rd_is_int, rd_is_win;
    logic [WIN_IDX_W-1:0] widx, ridx;
    reg_kind_e            wkind, rkind;

    assign wr_is_int = (wr_addr == INT_SEL);
    assign wr_is_win = !wr_addr[RA_W-1];
    assign widx      = wr_addr[WIN_IDX_W+1:2];
    assign wkind     = reg_kind_e'(wr_addr[1:0]);
    assign rd_is_int = (rd_addr == INT_SEL);
    assign rd_is_win = !rd_addr[RA_W-1];
    assign ridx      = rd_addr[WIN_IDX_W+1:2];
    assign rkind     = reg_kind_e'(rd_addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_WIN; i++) begin
                ctrl_q[i] <= '0;
                base_q[i] <= '0;
            end
            for (int j = 0; j < N_REMAP; j++) begin
                rlo_q[j] <= '0;
                rhi_q[j] <= '0;
            end
            ibase_q <= IB_RST;
        end else if (wr_en) begin
            if (wr_is_int) begin
                ibase_q <= wr_data;
            end else if (wr_is_win) begin
                case (wkind)
                    REG_CTRL: ctrl_q[widx] <= ctrl_clean(wr_data);
                    REG_BASE: base_q[widx] <= wr_data;
                    REG_RLO: begin
                        for (int j = 0; j < N_REMAP; j++)
                            if (widx == WIN_IDX_W'(j)) rlo_q[j] <= wr_data;
                    end
                    default: begin
                        for (int j = 0; j < N_REMAP; j++)
                            if (widx == WIN_IDX_W'(j)) rhi_q[j] <= wr_data;
                    end
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_is_int) begin
            rd_data = ibase_q;
        end else if (rd_is_win) begin
            case (rkind)
                REG_CTRL: rd_data = ctrl_q[ridx];
                REG_BASE: rd_data = base_q[ridx];
                REG_RLO: begin
                    for (int j = 0; j < N_REMAP; j++)
                        if (ridx == WIN_IDX_W'(j)) rd_data = rlo_q[j];
                end
                default: begin
                    for (int j = 0; j < N_REMAP; j++)
                        if (ridx == WIN_IDX_W'(j)) rd_data = rhi_q[j];
                end
            endcase
        end
    end

    for (genvar i = 0; i < N_WIN; i++) begin : g_out
        assign win_en[i]      = ctrl_q[i].en;
        assign win_size[i]    = ctrl_q[i].size_m1;
        assign win_tgt[i]     = ctrl_q[i].target;
        assign win_attr[i]    = ctrl_q[i].attr;
        assign win_base_hi[i] = base_q[i][31:16];
    end

    for (genvar j = 0; j < N_REMAP; j++) begin : g_remap
        assign win_remap[j] = {rhi_q[j], rlo_q[j]};
    end

    assign int_base_hi = ibase_q[AW-1:INT_REGION_LSB];

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
    import awd_pkg::*;
(
    input  logic          en,
    input  logic [15:0]   size_m1,
    input  logic [15:0]   base_hi,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] offset
);

    assign offset = addr - {base_hi, {GRAN_LSB{1'b0}}};
    assign hit    = en && (offset[AW-1:GRAN_LSB] <= size_m1);

endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic [N-1:0]  hits,
    input  logic [DW-1:0] data [N],
    output logic          any,
    output logic [DW-1:0] sel
);

    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                sel = data[i];
            end
        end
    end

endmodule

// File: rtl/awd_addr_decoder.sv
module awd_addr_decoder
    import awd_pkg::*;
#(
    parameter int N_WIN   = NUM_WIN,
    parameter int N_REMAP = NUM_REMAP,
    parameter logic [31:0] IB_RST = IBASE_RST
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [RA_W-1:0] wr_addr,
    input  logic [31:0]     wr_data,
    input  logic [RA_W-1:0] rd_addr,
    output logic [31:0]     rd_data,
    input  logic [AW-1:0]   lk_addr,
    output logic            lk_hit,
    output logic            lk_miss,
    output logic            lk_internal,
    output logic [TW-1:0]   lk_target,
    output logic [ATW-1:0]  lk_attr,
    output logic [FW-1:0]   lk_fwd_addr
);

    localparam int PAY_W = TW + ATW + FW;

    logic             win_en     [N_WIN];
    logic [15:0]      win_size   [N_WIN];
    logic [TW-1:0]    win_tgt    [N_WIN];
    logic [ATW-1:0]   win_attr   [N_WIN];
    logic [15:0]      win_base_hi[N_WIN];
    logic [FW-1:0]    win_remap  [N_REMAP];
    logic [AW-1:INT_REGION_LSB] int_base_hi;

    logic [N_WIN-1:0] hit_v;
    logic [AW-1:0]    off_v [N_WIN];
    logic [FW-1:0]    fwd_v [N_WIN];
    logic [PAY_W-1:0] pay_v [N_WIN];
    logic [PAY_W-1:0] sel_pay;
    logic             any_hit, int_hit;

    awd_regfile #(
        .N_WIN(N_WIN), .N_REMAP(N_REMAP), .IB_RST(IB_RST)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .win_en(win_en), .win_size(win_size), .win_tgt(win_tgt),
        .win_attr(win_attr), .win_base_hi(win_base_hi),
        .win_remap(win_remap), .int_base_hi(int_base_hi)
    );

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        awd_win_match u_match (
            .en(win_en[i]), .size_m1(win_size[i]), .base_hi(win_base_hi[i]),
            .addr(lk_addr), .hit(hit_v[i]), .offset(off_v[i])
        );
        if (i < N_REMAP) begin : g_rm
            assign fwd_v[i] = win_remap[i] + {{(FW-AW){1'b0}}, off_v[i]};
        end else begin : g_pass
            assign fwd_v[i] = {{(FW-AW){1'b0}}, lk_addr};
        end
        assign pay_v[i] = {win_tgt[i], win_attr[i], fwd_v[i]};
    end

    awd_prio_sel #(.N(N_WIN), .DW(PAY_W)) u_sel (
        .hits(hit_v), .data(pay_v), .any(any_hit), .sel(sel_pay)
    );

    assign int_hit     = (lk_addr[AW-1:INT_REGION_LSB] == int_base_hi);
    assign lk_internal = int_hit;
    assign lk_hit      = any_hit && !int_hit;
    assign lk_miss     = !any_hit && !int_hit;

    always_comb begin
        if (lk_hit) begin
            {lk_target, lk_attr, lk_fwd_addr} = sel_pay;
        end else begin
            lk_target   = '0;
            lk_attr     = '0;
            lk_fwd_addr = {{(FW-AW){1'b0}}, lk_addr};
        end
    end

endmodule

// File: rtl/awd_checker.sv
module awd_checker
    import awd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [RA_W-1:0] wr_addr,
    input logic [31:0]     wr_data,
    input logic [RA_W-1:0] rd_addr,
    input logic [31:0]     rd_data,
    input logic [AW-1:0]   lk_addr,
    input logic            lk_hit,
    input logic            lk_miss,
    input logic            lk_internal,
    input logic [TW-1:0]   lk_target,
    input logic [ATW-1:0]  lk_attr,
    input logic [FW-1:0]   lk_fwd_addr,
    input logic [AW-1:INT_REGION_LSB] int_base_hi
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot({lk_hit, lk_miss, lk_internal})); // R11

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        lk_miss |-> (lk_target == '0 && lk_attr == '0 &&
                     lk_fwd_addr == {{(FW-AW){1'b0}}, lk_addr})); // R11

    AST_INT_PRIO: assert property (@(posedge clk) disable iff (rst)
        (lk_addr[AW-1:INT_REGION_LSB] == int_base_hi) |->
            (lk_internal && !lk_hit && lk_target == '0)); // R8

    AST_RST_DISABLED: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !lk_internal) |-> lk_miss); // R1

    AST_IBASE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == INT_SEL) |=>
            (int_base_hi == $past(wr_data[AW-1:INT_REGION_LSB]))); // R9

    AST_REMAP_RO: assert property (@(posedge clk) disable iff (rst)
        (!rd_addr[RA_W-1] && rd_addr[1] &&
         rd_addr[WIN_IDX_W+1:2] >= WIN_IDX_W'(NUM_REMAP)) |-> (rd_data == '0)); // R7

endmodule

bind awd_addr_decoder awd_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_internal(lk_internal),
    .lk_target(lk_target), .lk_attr(lk_attr), .lk_fwd_addr(lk_fwd_addr),
    .int_base_hi(int_base_hi)
);

// File: tb/tb_awd_addr_decoder.sv
module tb_awd_addr_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] lk_addr = '0;
    logic        lk_hit, lk_miss, lk_internal;
    logic [3:0]  lk_target;
    logic [7:0]  lk_attr;
    logic [63:0] lk_fwd_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl [8];
    logic [31:0] m_base [8];
    logic [31:0] m_rlo  [8];
    logic [31:0] m_rhi  [8];
    logic [31:0] m_ibase;

    always #4 clk = ~clk;

    awd_addr_decoder dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_internal(lk_internal),
        .lk_target(lk_target), .lk_attr(lk_attr), .lk_fwd_addr(lk_fwd_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [5:0] a);
        int w;
        w = int'(a[4:2]);
        if (a == 6'h20) return m_ibase;
        if (a[5]) return 32'h0;
        case (a[1:0])
            2'd0: return m_ctrl[w] & ~32'hE;
            2'd1: return m_base[w];
            2'd2: return (w < 4) ? m_rlo[w] : 32'h0;
            default: return (w < 4) ? m_rhi[w] : 32'h0;
        endcase
    endfunction

    function automatic logic [78:0] model_lk(input logic [31:0] a);
        logic [31:0] off;
        if (a[31:20] == m_ibase[31:20])
            return {1'b0, 1'b0, 1'b1, 4'h0, 8'h0, 32'h0, a};
        for (int i = 0; i < 8; i++) begin
            off = a - {m_base[i][31:16], 16'h0};
            if (m_ctrl[i][0] && off[31:16] <= m_ctrl[i][31:16])
                return {1'b1, 1'b0, 1'b0, m_ctrl[i][7:4], m_ctrl[i][15:8],
                        (i < 4) ? ({m_rhi[i], m_rlo[i]} + {32'h0, off}) : {32'h0, a}};
        end
        return {1'b0, 1'b1, 1'b0, 4'h0, 8'h0, 32'h0, a};
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        int w;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        w = int'(a[4:2]);
        if (a == 6'h20) m_ibase = d;
        else if (!a[5]) begin
            case (a[1:0])
                2'd0: m_ctrl[w] = d;
                2'd1: m_base[w] = d;
                2'd2: if (w < 4) m_rlo[w] = d;
                default: if (w < 4) m_rhi[w] = d;
            endcase
        end
    endtask

    task automatic rd_chk(input logic [5:0] a, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_data === model_rd(a), req, {96'h0, rd_data}, {96'h0, model_rd(a)});
    endtask

    task automatic lk_chk(input logic [31:0] a, input string req);
        logic [78:0] act, exp;
        @(negedge clk);
        lk_addr = a;
        #1;
        act = {lk_hit, lk_miss, lk_internal, lk_target, lk_attr, lk_fwd_addr};
        exp = model_lk(a);
        chk(act === exp, req, {49'h0, act}, {49'h0, exp});
    endtask

    function automatic logic [31:0] ctrlw(input logic [15:0] sz, input logic [7:0] at,
                                          input logic [3:0] tg, input logic en);
        return {sz, at, tg, 3'b000, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, span;
        int w;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_ctrl[i] = '0; m_base[i] = '0; m_rlo[i] = '0; m_rhi[i] = '0;
        end
        m_ibase = 32'hF100_0000;
        repeat (3) @(posedge clk);
        wr_en = 1'b1; wr_addr = 6'h00; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b0;

        // R1: reset state
        rd_chk(6'h20, "R1 reset internal base");
        rd_chk(6'h00, "R1 reset ctrl0 (write during reset ignored)");
        lk_chk(32'h1234_5678, "R1 reset lookup misses");
        lk_chk(32'h0000_0000, "R1 reset lookup zero misses");

        // R2 R5 R6: window 2 with carry into remap high
        wr(6'h08, ctrlw(16'd3, 8'hA5, 4'd5, 1'b1));
        wr(6'h09, 32'h2000_1234);
        wr(6'h0A, 32'hFFFF_0000);
        wr(6'h0B, 32'h0000_0001);
        rd_chk(6'h09, "R2 base readback with low bits");
        rd_chk(6'h0B, "R2 remap high readback");
        lk_chk(32'h2000_0000, "R5 first byte hits");
        lk_chk(32'h2003_FFFF, "R6 last byte remap carry");
        lk_chk(32'h2004_0000, "R5 one past end misses");
        lk_chk(32'h1FFF_FFFF, "R5 one below base misses");
        lk_chk(32'h2001_2345, "R4 target and attribute");

        // R3: reserved control bits dropped
        wr(6'h08, ctrlw(16'd3, 8'hA5, 4'd5, 1'b1) | 32'hE);
        rd_chk(6'h08, "R3 reserved ctrl bits read zero");

        // R7: window 6 without remap
        wr(6'h18, ctrlw(16'd0, 8'h3C, 4'd9, 1'b1));
        wr(6'h19, 32'h3000_0000);
        wr(6'h1A, 32'h0000_DEAD);
        wr(6'h1B, 32'h0000_BEEF);
        rd_chk(6'h1A, "R7 remap low of window 6 reads zero");
        rd_chk(6'h1B, "R7 remap high of window 6 reads zero");
        lk_chk(32'h3000_8000, "R7 window 6 forwards address");

        // R10: overlapping lower window wins
        wr(6'h04, ctrlw(16'd15, 8'h11, 4'd7, 1'b1));
        wr(6'h05, 32'h2000_0000);
        lk_chk(32'h2002_0000, "R10 window 1 beats window 2");
        // R3: disabling window 1 hands the address back to window 2
        wr(6'h04, ctrlw(16'd15, 8'h11, 4'd7, 1'b0));
        lk_chk(32'h2002_0000, "R3 disabled window never hits");

        // R5: 4 GB window
        wr(6'h1C, ctrlw(16'hFFFF, 8'h77, 4'd3, 1'b1));
        wr(6'h1D, 32'h0000_0000);
        lk_chk(32'hFFFF_FFFF, "R5 full-space window top");
        lk_chk(32'h8000_0000, "R5 full-space window middle");

        // R8 R9: internal region priority and relocation
        lk_chk(32'hF10F_FFFF, "R8 internal region over full window");
        lk_chk(32'hF110_0000, "R8 just past internal region");
        wr(6'h20, 32'hD012_3456);
        rd_chk(6'h20, "R9 internal base exact readback");
        lk_chk(32'hD01A_0000, "R8 relocated internal region");
        lk_chk(32'hF100_0000, "R8 old internal region released");
        rd_chk(6'h21, "R2 unmapped select reads zero");

        // R11: miss after removing the full window
        wr(6'h1C, 32'h0);
        lk_chk(32'h7000_0000, "R11 miss drives zeros");

        // random phase
        for (int it = 0; it < 600; it++) begin
            if (it % 8 == 0) begin
                w = int'($urandom % 8);
                wr({1'b0, 3'(w), 2'd0},
                   {($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 32),
                    8'($urandom), 4'($urandom), 3'($urandom), ($urandom % 5 != 0)});
                wr({1'b0, 3'(w), 2'd1}, $urandom);
                wr({1'b0, 3'(w), 2'd2}, $urandom);
                wr({1'b0, 3'(w), 2'd3}, $urandom);
                rd_chk({1'b0, 3'(w), 2'($urandom)}, "R2 random readback");
            end
            w = int'($urandom % 8);
            if ($urandom % 4 == 0) begin
                a = $urandom;
            end else if ($urandom % 8 == 0) begin
                a = {m_ibase[31:20], 20'h0} + ($urandom % 32'h0020_0000) - 32'h0008_0000;
            end else if (m_ctrl[w][31:16] > 16'h0FFF) begin
                a = $urandom;
            end else begin
                span = ({16'h0, m_ctrl[w][31:16]} + 32'd2) << 16;
                a = {m_base[w][31:16], 16'h0} + ($urandom % span) - 32'h0000_8000;
            end
            lk_chk(a, "R10 R5 R6 random lookup");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule